// File: doc/BRIEF.md
# Audio Serial Port (I2S / PCM master)

This block is the master side of a two-channel audio serial link. It makes the bit clock and the frame clock itself. It shifts left and right sample words out on a data pin and captures words from an input pin. On the parallel side, one valid/ready stream supplies transmit samples and another returns received samples, each tagged with its channel. Software sets the frame format, the sample width and mono or stereo operation while the port is disabled. Raising `en` starts framing at the first bit of a frame.

Each slot is exactly one sample wide, so a frame holds 2×W bit clocks. Four events are recorded in sticky flags: a transmit slot that found no sample, a received word with nowhere to go, a sign change between consecutive samples of one transmit channel, and loss of an external bit clock while the port is marked as a clock slave. Writing 1 to a flag position on `flag_clr` clears that flag. When a set and a clear happen in the same cycle, the set wins.

Top module: `aud_serial_port`

## Requirements
- R1: `bclk` idles low while `en` is 0. Once enabled it runs with a period of 2×HALF_DIV system clocks. The first rising edge of `bclk` after enable carries bit position 0 of a frame. `sdo` and `lrclk` change only when `bclk` falls.
- R2: `wsel` sets the sample width W: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. Samples go out MSB first and occupy the low W bits of the data ports. A frame is 2×W bit clocks.
- R3: With `fmt`=0, `lrclk` is 0 for frame positions 0..W-1 and 1 for the rest. Each slot's data is delayed by one bit clock, so the left MSB is at position 1 and the right LSB is at position 0 of the next frame.
- R4: With `fmt`=1, `lrclk` is 1 for positions 0..W-1 and 0 otherwise. The left MSB is at position 0 and the right MSB is at position W.
- R5: With `fmt`=2, `lrclk` is a one-bit-clock pulse at position 0. Data is delayed by one bit clock: left occupies positions 1..W, then right follows.
- R6: With `fmt`=3, `lrclk` pulses at position 0 and the left MSB is also at position 0, with right following directly.
- R7: In stereo, transmit words are taken in the order left then right, one per slot. Each received word is presented once on `rx_data`, with `rx_left` set to 1 for the left slot.
- R8: With `mono`=1, one transmit word is taken per frame and sent in both slots. Only the slot selected by `mono_left` (1 for left, 0 for right) is received.
- R9: While `mute`=1, `sdo` stays 0 but `lrclk` timing and the consumption of transmit words are unchanged.
- R10: If no transmit word is valid when a slot needs one, flag bit 0 is set and that slot sends zeros.
- R11: If a received word is ready while `rx_valid` is still high and `rx_ready` is low, flag bit 1 is set. The new word is dropped and the held `rx_data` is kept.
- R12: Flag bit 2 (left) and flag bit 3 (right) are set when the sign bit (bit W-1) of a transmitted sample differs from that of the previous sample on the same channel. Each bit is set only if its channel enable is 1. The first sample after enable never sets a flag.
- R13: When `slave_mode`=1 and `ext_bclk` shows no edge for LOSS_CYCLES (256) system clocks, flag bit 4 is set. The flag is never set when `slave_mode`=0.
- R14: A 1 on `flag_clr[i]` clears flag i on the next clock, unless its condition recurs in that cycle. Other flag bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the serial port |
| fmt | input | 2 | Frame format code |
| wsel | input | 2 | Sample width code |
| mono | input | 1 | Mono operation |
| mono_left | input | 1 | Mono receive takes the left slot |
| mute | input | 1 | Send zero data |
| zc_en_l | input | 1 | Left zero-cross enable |
| zc_en_r | input | 1 | Right zero-cross enable |
| slave_mode | input | 1 | Watch `ext_bclk` for loss |
| ext_bclk | input | 1 | External bit clock under watch |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| tx_data | input | 32 | Transmit sample, low W bits used |
| rx_valid | output | 1 | Received sample held |
| rx_ready | input | 1 | Consumer accepts received sample |
| rx_data | output | 32 | Received sample, zero-extended |
| rx_left | output | 1 | Received sample came from the left slot |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame / channel clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| flag_clr | input | 5 | Write-1-to-clear for flags |
| flags | output | 5 | Sticky flags: underrun, overrun, zc left, zc right, clock lost |

## Verification
The hardest case to reach is a zero-cross detection that must ignore the very first sample after enable. It must also catch a sign change on the left channel while a right-channel change, with its enable off, stays silent. The stimulus cycles a four-word transmit queue whose signs are chosen so that both events fall on the second frame. The flags are sampled after the first frame and again after the second. The clock-loss case needs a long static stretch of `ext_bclk`. This is followed by a toggling stretch with a clear pulse in the middle, to show that a clear takes effect only once edges return.

// File: rtl/aud_ser_pkg.sv
// Package: shared codes, flag positions and the slot decoder of the audio port.
// Assumes frame position counts from 0 at the first bit clock of a frame.
package aud_ser_pkg;
    localparam int MAX_W   = 32;
    localparam int POS_W   = 6;
    localparam int N_FLAGS = 5;

    localparam int FLG_UNDERRUN = 0;
    localparam int FLG_OVERRUN  = 1;
    localparam int FLG_ZC_L     = 2;
    localparam int FLG_ZC_R     = 3;
    localparam int FLG_CLK_LOST = 4;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_MSBJ  = 2'd1,
        FMT_PCM_A = 2'd2,
        FMT_PCM_B = 2'd3
    } fmt_e;

    typedef struct packed {
        logic       lr;
        logic       right;
        logic [4:0] bit_idx;
        logic       first;
    } slot_t;

    // Mask keeping the low W bits of a sample.
    function automatic logic [MAX_W-1:0] width_mask(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Map a frame position to frame clock level, channel and bit index.
    function automatic slot_t decode_slot(input logic [1:0] fmt, input logic [1:0] wsel,
                                          input logic [POS_W-1:0] pos);
        int    w, f, p, d, off;
        slot_t s;
        w = 8 * (int'(wsel) + 1);
        f = 2 * w;
        p = int'(pos);
        if (fmt == FMT_I2S || fmt == FMT_PCM_A) d = (p == 0) ? f - 1 : p - 1;
        else                                    d = p;
        s.right   = (d >= w);
        off       = s.right ? d - w : d;
        s.bit_idx = 5'(w - 1 - off);
        s.first   = (off == 0);
        case (fmt)
            FMT_I2S:  s.lr = (p >= w);
            FMT_MSBJ: s.lr = (p < w);
            default:  s.lr = (p == 0);
        endcase
        return s;
    endfunction
endpackage

// File: rtl/aud_bclk_gen.sv
// Bit clock and frame position generator.
// Makes bclk from the system clock, counts frame position and drives lrclk.
// Assumes fmt/wsel change only while en is low. First tick after enable is a
// falling-edge action with bclk held low, so the first rising edge is position 0.
module aud_bclk_gen
    import aud_ser_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] fmt,
    input  logic [1:0] wsel,
    output logic       bclk,
    output logic       lrclk,
    output logic       fall_tick,
    output logic       rise_tick,
    output logic       nxt_right,
    output logic [4:0] nxt_bit,
    output logic       nxt_first,
    output logic       cur_right,
    output logic [4:0] cur_bit,
    output logic       cur_first
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] div_q;
    logic             running_q;
    logic [POS_W-1:0] pos_q, pos_nxt, frame_last;
    logic             tick;
    slot_t            s_cur, s_nxt;

    assign frame_last = {wsel, 4'hF};
    assign pos_nxt    = (pos_q == frame_last) ? '0 : pos_q + 1'b1;
    assign tick       = en && (div_q == CNT_W'(HALF_DIV - 1));
    assign fall_tick  = tick && (!running_q || bclk);
    assign rise_tick  = tick && running_q && !bclk;
    assign s_cur      = decode_slot(fmt, wsel, pos_q);
    assign s_nxt      = decode_slot(fmt, wsel, pos_nxt);
    assign nxt_right  = s_nxt.right;
    assign nxt_bit    = s_nxt.bit_idx;
    assign nxt_first  = s_nxt.first;
    assign cur_right  = s_cur.right;
    assign cur_bit    = s_cur.bit_idx;
    assign cur_first  = s_cur.first;

    // Divider, bit clock phase, frame position and frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q     <= '0;
            running_q <= 1'b0;
            bclk      <= 1'b0;
            lrclk     <= 1'b0;
            pos_q     <= frame_last;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                if (!running_q) running_q <= 1'b1;
                else            bclk      <= !bclk;
            end
            if (fall_tick) begin
                pos_q <= pos_nxt;
                lrclk <= s_nxt.lr;
            end
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk && !lrclk));
    p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(lrclk) |-> !bclk);
endmodule

// File: rtl/aud_tx_path.sv
// Transmit path: fetches samples per slot, applies mute and underrun zeroing,
// shifts bits out on falling ticks and detects sign changes per channel.
// Assumes the slot info given is that of the position entered at fall_tick.
module aud_tx_path
    import aud_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fall_tick,
    input  logic             nxt_right,
    input  logic [4:0]       nxt_bit,
    input  logic             nxt_first,
    input  logic [1:0]       wsel,
    input  logic             mono,
    input  logic             mute,
    input  logic [1:0]       zc_en,
    input  logic             tx_valid,
    input  logic [MAX_W-1:0] tx_data,
    output logic             tx_ready,
    output logic             sdo,
    output logic             underrun_evt,
    output logic [1:0]       zc_evt
);
    logic             need_fetch, load, sign;
    logic [MAX_W-1:0] src, cur_q, mono_q;
    logic [1:0]       have_prev_q, prev_sign_q;
    logic [4:0]       sign_idx;

    assign need_fetch   = nxt_first && (!mono || !nxt_right);
    assign tx_ready     = fall_tick && need_fetch;
    assign load         = fall_tick && nxt_first;
    assign underrun_evt = tx_ready && !tx_valid;
    assign sign_idx     = {wsel, 3'b111};
    assign sign         = src[sign_idx];

    // Word entering the slot: stream word, zeros, or the repeated mono word.
    always_comb begin
        if (need_fetch) src = (tx_valid && !mute) ? (tx_data & width_mask(wsel)) : '0;
        else            src = mono_q;
    end

    // Zero-cross events, one per channel (0 = left, 1 = right).
    for (genvar c = 0; c < 2; c++) begin : g_zc
        assign zc_evt[c] = load && (nxt_right == 1'(c)) && zc_en[c]
                           && have_prev_q[c] && (prev_sign_q[c] != sign);
    end

    // Slot word, serial bit and per-channel sign history.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cur_q       <= '0;
            mono_q      <= '0;
            sdo         <= 1'b0;
            have_prev_q <= '0;
            prev_sign_q <= '0;
        end else if (fall_tick) begin
            if (load) begin
                cur_q                  <= src;
                sdo                    <= src[nxt_bit];
                have_prev_q[nxt_right] <= 1'b1;
                prev_sign_q[nxt_right] <= sign;
                if (need_fetch) mono_q <= src;
            end else begin
                sdo <= cur_q[nxt_bit];
            end
        end
    end
endmodule

// File: rtl/aud_rx_path.sv
// Receive path: samples sdi on rising ticks, assembles a word per slot and
// holds it on a valid/ready output; reports overrun when the holder is busy.
// Assumes slot info is that of the current position at rise_tick.
module aud_rx_path
    import aud_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise_tick,
    input  logic             cur_right,
    input  logic [4:0]       cur_bit,
    input  logic             cur_first,
    input  logic [1:0]       wsel,
    input  logic             mono,
    input  logic             mono_left,
    input  logic             sdi,
    input  logic             rx_ready,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_left,
    output logic             overrun_evt
);
    logic [MAX_W-2:0] sh_q;
    logic             armed_q, capture, emit;
    logic [MAX_W-1:0] word;

    assign capture     = !mono || (mono_left == !cur_right);
    assign emit        = en && rise_tick && armed_q && (cur_bit == 5'd0) && capture;
    assign word        = {sh_q, sdi} & width_mask(wsel);
    assign overrun_evt = emit && rx_valid && !rx_ready;

    // Shift register, slot arming and output holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            armed_q  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_left  <= 1'b0;
        end else begin
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (!en) begin
                armed_q <= 1'b0;
            end else if (rise_tick) begin
                sh_q <= {sh_q[MAX_W-3:0], sdi};
                if (cur_first) armed_q <= 1'b1;
                if (emit && !(rx_valid && !rx_ready)) begin
                    rx_data  <= word;
                    rx_valid <= 1'b1;
                    rx_left  <= !cur_right;
                end
            end
        end
    end

    p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/aud_clk_watch.sv
// Bit clock loss watchdog for slave operation.
// Synchronises ext_bclk, counts system clocks without an edge and reports loss.
// Assumes ext_bclk is asynchronous to clk.
module aud_clk_watch #(
    parameter int LOSS_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic ext_bclk,
    output logic lost_evt
);
    localparam int CNT_W = $clog2(LOSS_CYCLES + 1);

    logic [2:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_seen;

    assign edge_seen = sync_q[2] ^ sync_q[1];
    assign lost_evt  = slave_mode && (cnt_q == CNT_W'(LOSS_CYCLES));

    // Synchroniser and edge-free interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_bclk};
            if (!slave_mode || edge_seen)          cnt_q <= '0;
            else if (cnt_q != CNT_W'(LOSS_CYCLES)) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/aud_serial_port.sv
// Top of the master audio serial port. Wires the bit clock generator, the
// transmit and receive paths and the clock watchdog, and keeps sticky flags.
// Assumes configuration inputs change only while en is low.
module aud_serial_port
    import aud_ser_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int LOSS_CYCLES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [1:0]         fmt,
    input  logic [1:0]         wsel,
    input  logic               mono,
    input  logic               mono_left,
    input  logic               mute,
    input  logic               zc_en_l,
    input  logic               zc_en_r,
    input  logic               slave_mode,
    input  logic               ext_bclk,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [MAX_W-1:0]   tx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic [MAX_W-1:0]   rx_data,
    output logic               rx_left,
    output logic               bclk,
    output logic               lrclk,
    output logic               sdo,
    input  logic               sdi,
    input  logic [N_FLAGS-1:0] flag_clr,
    output logic [N_FLAGS-1:0] flags
);
    logic             fall_tick, rise_tick;
    logic             nxt_right, nxt_first, cur_right, cur_first;
    logic [4:0]       nxt_bit, cur_bit;
    logic             underrun_evt, overrun_evt, lost_evt;
    logic [1:0]       zc_evt;
    logic [N_FLAGS-1:0] set_vec;

    aud_bclk_gen #(.HALF_DIV(HALF_DIV)) i_bclk_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .wsel(wsel),
        .bclk(bclk), .lrclk(lrclk), .fall_tick(fall_tick), .rise_tick(rise_tick),
        .nxt_right(nxt_right), .nxt_bit(nxt_bit), .nxt_first(nxt_first),
        .cur_right(cur_right), .cur_bit(cur_bit), .cur_first(cur_first)
    );

    aud_tx_path i_tx_path (
        .clk(clk), .rst_n(rst_n), .en(en), .fall_tick(fall_tick),
        .nxt_right(nxt_right), .nxt_bit(nxt_bit), .nxt_first(nxt_first),
        .wsel(wsel), .mono(mono), .mute(mute), .zc_en({zc_en_r, zc_en_l}),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .sdo(sdo),
        .underrun_evt(underrun_evt), .zc_evt(zc_evt)
    );

    aud_rx_path i_rx_path (
        .clk(clk), .rst_n(rst_n), .en(en), .rise_tick(rise_tick),
        .cur_right(cur_right), .cur_bit(cur_bit), .cur_first(cur_first),
        .wsel(wsel), .mono(mono), .mono_left(mono_left), .sdi(sdi),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_left(rx_left), .overrun_evt(overrun_evt)
    );

    aud_clk_watch #(.LOSS_CYCLES(LOSS_CYCLES)) i_clk_watch (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .ext_bclk(ext_bclk), .lost_evt(lost_evt)
    );

    assign set_vec[FLG_UNDERRUN] = underrun_evt;
    assign set_vec[FLG_OVERRUN]  = overrun_evt;
    assign set_vec[FLG_ZC_L]     = zc_evt[0];
    assign set_vec[FLG_ZC_R]     = zc_evt[1];
    assign set_vec[FLG_CLK_LOST] = lost_evt;

    // Sticky flags: an event sets the flag, a 1 on flag_clr clears it, set wins.
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_vec[i] | (flags[i] & ~flag_clr[i]);
        end

        p_w1c_r14: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && flag_clr[i] && !set_vec[i]) |=> !flags[i]);
    end

    p_sdo_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && $past(bclk)) |-> $stable(sdo));
    p_lost_slave_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CLK_LOST]) |-> $past(slave_mode));
endmodule

// File: tb/test_aud_serial_port.sv
`timescale 1ns/1ps
module test_aud_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  fmt = 2'd0, wsel = 2'd0;
    logic        mono = 1'b0, mono_left = 1'b0, mute = 1'b0;
    logic        zc_en_l = 1'b0, zc_en_r = 1'b0;
    logic        slave_mode = 1'b0, ext_bclk = 1'b0;
    logic        tx_valid = 1'b1, tx_ready;
    logic [31:0] tx_data;
    logic        rx_valid, rx_ready = 1'b1, rx_left;
    logic [31:0] rx_data;
    logic        bclk, lrclk, sdo, sdi;
    logic [4:0]  flag_clr = 5'd0, flags;

    int n_chk = 0, n_bad = 0;
    int tx_hs = 0, tx_base = 0, rx_n = 0;
    logic [31:0] q [4];
    logic [31:0] rx_log [64];
    logic        rxl_log [64];
    logic        exp_zero = 1'b0;

    always #2.5 clk = ~clk;

    assign sdi     = sdo;
    assign tx_data = q[(tx_hs - tx_base) & 3];

    aud_serial_port i_aud_serial_port (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .wsel(wsel), .mono(mono),
        .mono_left(mono_left), .mute(mute), .zc_en_l(zc_en_l), .zc_en_r(zc_en_r),
        .slave_mode(slave_mode), .ext_bclk(ext_bclk), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_left(rx_left), .bclk(bclk),
        .lrclk(lrclk), .sdo(sdo), .sdi(sdi), .flag_clr(flag_clr), .flags(flags)
    );

    // Stream bookkeeping: count transmit handshakes, log received words.
    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_hs <= tx_hs + 1;
        if (rx_valid && rx_ready) begin
            rx_log[rx_n % 64]  <= rx_data;
            rxl_log[rx_n % 64] <= rx_left;
            rx_n <= rx_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Enable and watch nfr frames on the pins against the frame rules.
    task automatic run_frames(input int nfr, output int bit_err, output int lr_err,
                              output int ones);
        int w, f;
        w = 8 * (int'(wsel) + 1);
        f = 2 * w;
        bit_err = 0; lr_err = 0; ones = 0;
        @(negedge clk) en = 1'b1;
        for (int k = 0; k < nfr * f; k++) begin
            int p, dabs, fr, off, ch, bi, slot;
            logic elr, ebit;
            logic [31:0] word;
            @(posedge bclk); #1;
            p = k % f;
            case (fmt)
                2'd0:    elr = (p >= w);
                2'd1:    elr = (p < w);
                default: elr = (p == 0);
            endcase
            if (lrclk !== elr) lr_err++;
            if (sdo) ones++;
            dabs = (fmt == 2'd0 || fmt == 2'd2) ? k - 1 : k;
            if (dabs >= 0) begin
                fr   = dabs / f;
                off  = dabs % f;
                ch   = off / w;
                bi   = w - 1 - off % w;
                slot = mono ? fr : fr * 2 + ch;
                word = exp_zero ? 32'd0 : q[slot % 4];
                ebit = word[bi];
                if (sdo !== ebit) bit_err++;
            end
        end
    endtask

    task automatic stop_port();
        @(negedge clk) en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] f, input logic [1:0] ws, input logic m,
                         input logic ml, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d);
        @(negedge clk);
        fmt = f; wsel = ws; mono = m; mono_left = ml;
        q[0] = a; q[1] = b; q[2] = c; q[3] = d;
        tx_base = tx_hs;
    endtask

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  wsel;
        logic        mono;
        logic        msel;
        logic [31:0] l;
        logic [31:0] r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_A5C3, 32'h0000_1234},   // R3 16-bit
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'h0080_0001, 32'h007F_FF0F},   // R4 24-bit
        '{2'd2, 2'd0, 1'b0, 1'b0, 32'h0000_005A, 32'h0000_00C3},   // R5 8-bit
        '{2'd3, 2'd3, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0123_4567},   // R6 32-bit
        '{2'd0, 2'd0, 1'b1, 1'b1, 32'h0000_0096, 32'h0000_0000},   // R8 mono left
        '{2'd3, 2'd1, 1'b1, 1'b0, 32'h0000_8421, 32'h0000_0000}    // R8 mono right
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        int be, le, on, rxb;
        realtime t0;
        repeat (4) @(negedge clk);
        // Reset state (R1, R14)
        chk("R1 bclk in reset", {31'd0, bclk}, 32'd0);
        chk("R1 lrclk in reset", {31'd0, lrclk}, 32'd0);
        chk("R14 flags in reset", {27'd0, flags}, 32'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 bclk idle while disabled", {31'd0, bclk}, 32'd0);
        chk("R7 rx_valid idle", {31'd0, rx_valid}, 32'd0);

        // Table of formats, widths and channel modes (R2..R8)
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            t = VECS[v];
            if (t.mono) setup(t.fmt, t.wsel, 1'b1, t.msel, t.l, t.l, t.l, t.l);
            else        setup(t.fmt, t.wsel, 1'b0, 1'b0, t.l, t.r, t.l, t.r);
            rxb = rx_n;
            run_frames(2, be, le, on);
            chk($sformatf("R2 R3 R4 R5 R6 data bits vec%0d", v), be, 0);
            chk($sformatf("R3 R4 R5 R6 lrclk vec%0d", v), le, 0);
            stop_port();
            chk($sformatf("R7 R8 first rx word vec%0d", v), rx_log[rxb % 64], t.l);
            if (t.mono) begin
                chk($sformatf("R8 rx channel tag vec%0d", v), {31'd0, rxl_log[rxb % 64]}, {31'd0, t.msel});
                chk($sformatf("R8 one tx word per frame vec%0d", v), tx_hs - tx_base, 2);
            end else begin
                chk($sformatf("R7 left tag vec%0d", v), {31'd0, rxl_log[rxb % 64]}, 32'd1);
                chk($sformatf("R7 second rx word vec%0d", v), rx_log[(rxb + 1) % 64], t.r);
                chk($sformatf("R7 right tag vec%0d", v), {31'd0, rxl_log[(rxb + 1) % 64]}, 32'd0);
            end
        end
        chk("R10 no underrun with valid stream", {27'd0, flags}, 32'd0);

        // Bit clock period (R1)
        setup(2'd1, 2'd0, 1'b0, 1'b0, 32'h11, 32'h22, 32'h11, 32'h22);
        @(negedge clk) en = 1'b1;
        @(posedge bclk); t0 = $realtime;
        @(posedge bclk);
        chk("R1 bclk period ns", int'($realtime - t0), 20);
        stop_port();
        chk("R1 bclk low after disable", {31'd0, bclk}, 32'd0);

        // Mute keeps framing and consumption (R9)
        setup(2'd1, 2'd0, 1'b0, 1'b0, 32'hFF, 32'h81, 32'h7F, 32'h18);
        mute = 1'b1; exp_zero = 1'b1;
        run_frames(2, be, le, on);
        chk("R9 muted sdo ones", on, 0);
        chk("R9 muted lrclk timing", le, 0);
        chk("R9 words consumed under mute", tx_hs - tx_base, 4);
        stop_port();
        mute = 1'b0; exp_zero = 1'b0;

        // Underrun (R10) then write-1-to-clear (R14)
        setup(2'd1, 2'd0, 1'b0, 1'b0, 32'hFF, 32'hFF, 32'hFF, 32'hFF);
        tx_valid = 1'b0; exp_zero = 1'b1;
        run_frames(1, be, le, on);
        chk("R10 zeros on underrun", on, 0);
        chk("R10 underrun flag", {31'd0, flags[0]}, 32'd1);
        stop_port();
        tx_valid = 1'b1; exp_zero = 1'b0;
        @(negedge clk) flag_clr = 5'b00001;
        @(negedge clk) flag_clr = 5'b00000;
        chk("R14 underrun cleared", {27'd0, flags}, 32'd0);

        // Overrun keeps held word (R11)
        setup(2'd1, 2'd0, 1'b0, 1'b0, 32'h11, 32'h22, 32'h33, 32'h44);
        rx_ready = 1'b0;
        run_frames(2, be, le, on);
        chk("R11 rx_valid held", {31'd0, rx_valid}, 32'd1);
        chk("R11 held word kept", rx_data, 32'h11);
        chk("R11 held tag", {31'd0, rx_left}, 32'd1);
        chk("R11 overrun flag", {31'd0, flags[1]}, 32'd1);
        stop_port();
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) flag_clr = 5'b00010;
        @(negedge clk) flag_clr = 5'b00000;
        chk("R14 overrun cleared only", {27'd0, flags}, 32'd0);

        // Zero cross (R12): left enabled, right disabled
        setup(2'd1, 2'd0, 1'b0, 1'b0, 32'h90, 32'h81, 32'h12, 32'h13);
        zc_en_l = 1'b1; zc_en_r = 1'b0;
        run_frames(1, be, le, on);
        chk("R12 first sample no zero cross", {31'd0, flags[2]}, 32'd0);
        run_frames(1, be, le, on);
        chk("R12 left zero cross", {31'd0, flags[2]}, 32'd1);
        chk("R12 right disabled", {31'd0, flags[3]}, 32'd0);
        stop_port();
        zc_en_l = 1'b0;
        @(negedge clk) flag_clr = 5'b00100;
        @(negedge clk) flag_clr = 5'b00000;

        // Clock loss (R13) and independent clears (R14)
        @(negedge clk) slave_mode = 1'b1;
        repeat (250) @(negedge clk);
        chk("R13 no loss before limit", {31'd0, flags[4]}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R13 loss flagged", {31'd0, flags[4]}, 32'd1);
        @(negedge clk) flag_clr = 5'b00001;
        @(negedge clk) flag_clr = 5'b00000;
        chk("R14 other clear leaves loss flag", {31'd0, flags[4]}, 32'd1);
        for (int i = 0; i < 40; i++) begin
            repeat (8) @(negedge clk);
            ext_bclk = ~ext_bclk;
            if (i == 3) begin
                flag_clr = 5'b10000;
                @(negedge clk) flag_clr = 5'b00000;
            end
        end
        chk("R13 R14 cleared with live clock", {31'd0, flags[4]}, 32'd0);
        @(negedge clk) slave_mode = 1'b0;
        repeat (400) @(negedge clk);
        chk("R13 no loss in master mode", {31'd0, flags[4]}, 32'd0);

        summary();
    end
endmodule